// File: doc/BRIEF.md
# Sequential double-width integer divider

This block divides a double-width dividend by a single-width divisor, one quotient bit per clock. It works like the divide step of an accumulator-style processor. One unit serves byte, word and doubleword operand sizes, in both unsigned and two's-complement signed arithmetic. The operands arrive as a high 32-bit half, a low 32-bit half and a divisor. The unit returns the two halves again, with the quotient written into the low part and the remainder into the high part for the selected size. Bits outside the selected size keep their input values.

A single unsigned restoring core does all the work. Before the core runs, the operands are reduced to magnitudes by bitwise inversion plus one. After the core finishes, the results are given their signs again by the same method. A divisor of zero raises an error flag, and so does a quotient that cannot be represented in the selected size. In both cases the returned halves are the operands exactly as supplied.

Top module: `divider_unit`

## Requirements
- R1: While reset is held and after it is released, `hi_out`, `lo_out`, `done`, `err` and `busy` are all zero.
- R2: `size` selects the operand width N. Code 0 is byte (N=8), code 1 is word (N=16), and codes 2 and 3 are doubleword (N=32). The dividend is `lo_in[15:0]` for byte, `{hi_in[15:0],lo_in[15:0]}` for word and `{hi_in,lo_in}` for doubleword. The divisor is `divisor[N-1:0]`.
- R3: Result placement. For byte, the quotient goes to `lo_out[7:0]` and the remainder to `lo_out[15:8]`. For word, the quotient goes to `lo_out[15:0]` and the remainder to `hi_out[15:0]`. For doubleword, the quotient is `lo_out` and the remainder is `hi_out`. Every other bit of `hi_out` and `lo_out` equals the matching bit of `hi_in` or `lo_in`.
- R4: With `sgn`=0, both operands are unsigned magnitudes, and the result is the floor quotient with its remainder.
- R5: With `sgn`=1, both operands are two's complement. The quotient truncates toward zero, and a nonzero remainder carries the dividend's sign. For example, -22 divided by 22 gives a quotient of -1 and a remainder of 0.
- R6: A zero divisor (its low N bits) sets `err` with `done`, and `hi_out`/`lo_out` return `hi_in`/`lo_in` unchanged.
- R7: A quotient of 2^N or more (unsigned), or one outside -2^(N-1)..2^(N-1)-1 (signed), sets `err` with `done` and returns the operand halves unchanged.
- R8: When `start` is sampled at an idle clock edge k, `busy` is high from edge k on. `done` is a one-cycle pulse after edge k+N+2, and `busy` falls at that same edge.
- R9: `start` has no effect while `busy` is high. It produces no extra `done`, and the running operation's result is unaffected.
- R10: `err` is valid with `done` and holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a divide when idle |
| size | input | 2 | Operand size code |
| sgn | input | 1 | 1 = signed, 0 = unsigned |
| hi_in | input | 32 | High half of dividend |
| lo_in | input | 32 | Low half of dividend |
| divisor | input | 32 | Divisor (low N bits used) |
| hi_out | output | 32 | High half of result (remainder part) |
| lo_out | output | 32 | Low half of result (quotient part) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Divide-by-zero or quotient overflow |
| busy | output | 1 | Operation in progress |

## Verification
Each result is due N+2 edges after the edge that samples `start`. That is one edge to form magnitudes, N edges of the core and one edge for the sign fix. The driver records the cycle index of the sampling edge and queues the due cycle together with the expected halves and error flag. The monitor pops an entry only on a `done` pulse and compares the current cycle with the queued one. A pulse that is late, early or extra is therefore reported as well as a wrong value. `err` is checked again one cycle after the unit goes idle, to confirm that it held.

// File: rtl/divider_unit.sv
module divider_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  size,
  input  logic        sgn,
  input  logic [31:0] hi_in,
  input  logic [31:0] lo_in,
  input  logic [31:0] divisor,
  output logic [31:0] hi_out,
  output logic [31:0] lo_out,
  output logic        done,
  output logic        err,
  output logic        busy
);
  typedef enum logic [1:0] {IDLE, PREP, RUN, FIX} state_t;

  state_t      st;
  logic [1:0]  sz_l;
  logic        sg_l, ovf;
  logic [31:0] hi_l, lo_l, dv_l, rem, vm;
  logic [63:0] dq;
  logic [5:0]  cnt, nb;

  logic [63:0] dext, dmag, lowal;
  logic [31:0] vext, vmag, up;
  logic        d_neg, v_neg;

  always_comb begin
    case (sz_l)
      2'd0: begin
        nb    = 6'd8;
        dext  = sg_l ? {{48{lo_l[15]}}, lo_l[15:0]} : {48'b0, lo_l[15:0]};
        vext  = sg_l ? {{24{dv_l[7]}}, dv_l[7:0]} : {24'b0, dv_l[7:0]};
      end
      2'd1: begin
        nb    = 6'd16;
        dext  = sg_l ? {{32{hi_l[15]}}, hi_l[15:0], lo_l[15:0]} : {32'b0, hi_l[15:0], lo_l[15:0]};
        vext  = sg_l ? {{16{dv_l[15]}}, dv_l[15:0]} : {16'b0, dv_l[15:0]};
      end
      default: begin
        nb    = 6'd32;
        dext  = {hi_l, lo_l};
        vext  = dv_l;
      end
    endcase
  end

  assign d_neg = sg_l & dext[63];
  assign v_neg = sg_l & vext[31];
  assign dmag  = d_neg ? ~dext + 64'd1 : dext;
  assign vmag  = v_neg ? ~vext + 32'd1 : vext;

  always_comb begin
    case (sz_l)
      2'd0:    begin up = {24'b0, dmag[15:8]};  lowal = {dmag[7:0], 56'b0};  end
      2'd1:    begin up = {16'b0, dmag[31:16]}; lowal = {dmag[15:0], 48'b0}; end
      default: begin up = dmag[63:32];          lowal = {dmag[31:0], 32'b0}; end
    endcase
  end

  logic [32:0] trial;
  logic [33:0] diff;
  logic        take;
  assign trial = {rem, dq[63]};
  assign diff  = {1'b0, trial} + {1'b0, ~{1'b0, vm}} + 34'd1;
  assign take  = diff[33];

  logic [31:0] qmag, half, qres, rres, hi_n, lo_n;
  logic        qneg, sovf, bad;
  assign qmag = dq[31:0];
  assign half = 32'd1 << (nb - 6'd1);
  assign qneg = d_neg ^ v_neg;
  assign sovf = sg_l & (qneg ? (qmag > half) : (qmag >= half));
  assign bad  = ovf | sovf;
  assign qres = qneg ? ~qmag + 32'd1 : qmag;
  assign rres = d_neg ? ~rem + 32'd1 : rem;

  always_comb begin
    case (sz_l)
      2'd0:    begin hi_n = hi_l;                      lo_n = {lo_l[31:16], rres[7:0], qres[7:0]}; end
      2'd1:    begin hi_n = {hi_l[31:16], rres[15:0]}; lo_n = {lo_l[31:16], qres[15:0]};           end
      default: begin hi_n = rres;                      lo_n = qres;                                end
    endcase
  end

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; sz_l <= '0; sg_l <= 1'b0; ovf <= 1'b0;
      hi_l <= '0; lo_l <= '0; dv_l <= '0; rem <= '0; vm <= '0;
      dq <= '0; cnt <= '0;
      hi_out <= '0; lo_out <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          sz_l <= size; sg_l <= sgn;
          hi_l <= hi_in; lo_l <= lo_in; dv_l <= divisor;
          st <= PREP;
        end
        PREP: begin
          rem <= up; vm <= vmag; dq <= lowal;
          ovf <= (up >= vmag);
          cnt <= nb;
          st  <= RUN;
        end
        RUN: begin
          rem <= take ? diff[31:0] : trial[31:0];
          dq  <= {dq[62:0], take};
          cnt <= cnt - 6'd1;
          if (cnt == 6'd1) st <= FIX;
        end
        default: begin
          hi_out <= bad ? hi_l : hi_n;
          lo_out <= bad ? lo_l : lo_n;
          err    <= bad;
          done   <= 1'b1;
          st     <= IDLE;
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(dv_l) && $stable(hi_l) && $stable(lo_l)); // R9
  AST_ERR_KEEPS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n) (done && err) |-> (hi_out == hi_l) && (lo_out == lo_l)); // R6
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n) (st == RUN && !ovf) |-> (rem < vm)); // R4
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !done |=> (done || $stable(err))); // R10
endmodule

// File: tb/tb_divider_unit.sv
`timescale 1ns/1ps
module tb_divider_unit;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, sgn = 1'b0;
  logic [1:0]  size = '0;
  logic [31:0] hi_in = '0, lo_in = '0, divisor = '0;
  logic [31:0] hi_out, lo_out;
  logic        done, err, busy;

  divider_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .size(size), .sgn(sgn),
    .hi_in(hi_in), .lo_in(lo_in), .divisor(divisor), .hi_out(hi_out), .lo_out(lo_out),
    .done(done), .err(err), .busy(busy));

  always #2.5 clk = ~clk;

  typedef struct { longint due; logic [31:0] hi, lo; logic e; string tag; } exp_t;
  exp_t sb[$];
  int nchk = 0, nerr = 0;
  longint cyc = 0;
  logic last_err = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] s, input logic g,
                                 input logic [31:0] h, input logic [31:0] l, input logic [31:0] d);
    exp_t r;
    int n;
    logic [63:0] m2, de, dm, vm, qm, rm, qv, rv, lim;
    logic [31:0] m1, ve;
    logic neg, bad;
    n  = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    m2 = (n == 32) ? '1 : ((64'd1 << (2*n)) - 64'd1);
    m1 = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    if (n == 8)       de = {48'b0, l[15:0]};
    else if (n == 16) de = {32'b0, h[15:0], l[15:0]};
    else              de = {h, l};
    if (g && de[2*n-1]) de = de | ~m2;
    ve = d & m1;
    if (g && ve[n-1]) ve = ve | ~m1;
    dm = (g && de[63]) ? -de : de;
    vm = {32'b0, (g && ve[31]) ? -ve : ve};
    r.hi = h; r.lo = l; r.e = 1'b1; r.due = 0; r.tag = "";
    if (vm == 0) return r;
    qm  = dm / vm;
    rm  = dm % vm;
    neg = g && (de[63] ^ ve[31]);
    if (g) begin
      lim = 64'd1 << (n-1);
      bad = neg ? (qm > lim) : (qm >= lim);
    end else bad = (qm >= (64'd1 << n));
    if (bad) return r;
    qv = neg ? -qm : qm;
    rv = (g && de[63]) ? -rm : rm;
    r.e = 1'b0;
    if (n == 8)       r.lo = {l[31:16], rv[7:0], qv[7:0]};
    else if (n == 16) begin r.lo = {l[31:16], qv[15:0]}; r.hi = {h[31:16], rv[15:0]}; end
    else              begin r.lo = qv[31:0]; r.hi = rv[31:0]; end
    return r;
  endfunction

  task automatic issue(input logic [1:0] s, input logic g, input logic [31:0] h,
                       input logic [31:0] l, input logic [31:0] d, input string tag);
    exp_t e;
    int n;
    n = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    e = model(s, g, h, l, d);
    e.tag = tag;
    @(negedge clk);
    size = s; sgn = g; hi_in = h; lo_in = l; divisor = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e.due = cyc + n + 2;
    sb.push_back(e);
    last_err = e.e;
    check(busy === 1'b1, "R8", "busy after start", {63'b0, busy}, 64'd1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R8", "pending results", sb.size(), 0);
    check(err === last_err, "R10", "err held", {63'b0, err}, {63'b0, last_err});
  endtask

  task automatic run(input logic [1:0] s, input logic g, input logic [31:0] h,
                     input logic [31:0] l, input logic [31:0] d, input string tag);
    issue(s, g, h, l, d, tag);
    wait_idle();
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) check(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(cyc == e.due, "R8", "done cycle", cyc, e.due);
        check(hi_out === e.hi, e.tag, "hi_out", {32'b0, hi_out}, {32'b0, e.hi});
        check(lo_out === e.lo, e.tag, "lo_out", {32'b0, lo_out}, {32'b0, e.lo});
        check(err === e.e, e.tag, "err", {63'b0, err}, {63'b0, e.e});
      end
    end
  end

  initial begin
    #(200000 * 5);
    check(1'b0, "WATCHDOG", "timeout", 64'd1, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  task automatic pack(input logic [1:0] s, input logic [63:0] dd,
                      output logic [31:0] h, output logic [31:0] l);
    logic [31:0] j;
    j = $urandom;
    if (s == 2'd0)      begin h = $urandom; l = {j[15:0], dd[15:0]}; end
    else if (s == 2'd1) begin h = {j[31:16], dd[31:16]}; l = {j[15:0], dd[15:0]}; end
    else                begin h = dd[63:32]; l = dd[31:0]; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hi_out === 32'd0, "R1", "hi_out", {32'b0, hi_out}, 0);
    check(lo_out === 32'd0, "R1", "lo_out", {32'b0, lo_out}, 0);
    check(done === 1'b0, "R1", "done", {63'b0, done}, 0);
    check(err === 1'b0, "R1", "err", {63'b0, err}, 0);
    check(busy === 1'b0, "R1", "busy", {63'b0, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "idle after reset", {62'b0, busy, done}, 0);

    run(2'd2, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFEA, 32'd22, "R5");
    run(2'd2, 1'b1, 32'd7, 32'd21, 32'd22, "R5");
    run(2'd1, 1'b1, 32'hABCD_FFFF, 32'h1234_FFF9, 32'h0000_0002, "R5");
    run(2'd0, 1'b1, 32'h5555_5555, 32'h9876_FFF9, 32'hFFFF_FFFE, "R5");
    run(2'd0, 1'b0, 32'hDEAD_BEEF, 32'hCAFE_03E8, 32'h0000_0007, "R3");
    run(2'd1, 1'b0, 32'h1111_0003, 32'h2222_0001, 32'h0000_1000, "R3");
    run(2'd3, 1'b0, 32'h0000_0001, 32'h0000_0000, 32'h0000_0003, "R2");
    run(2'd0, 1'b0, 32'h0, 32'h0000_1234, 32'hFFFF_FF00, "R6");
    run(2'd2, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0, "R6");
    run(2'd0, 1'b0, 32'h0, 32'h0000_1000, 32'h1, "R7");
    run(2'd0, 1'b1, 32'h0, 32'h0000_8000, 32'hFF, "R7");
    run(2'd0, 1'b1, 32'h0, 32'h0000_8000, 32'h100, "R7");
    run(2'd0, 1'b1, 32'h0, 32'h0000_4000, 32'h80, "R7");
    run(2'd1, 1'b1, 32'h0000_8000, 32'h0000_0000, 32'h0000_0001, "R7");
    run(2'd2, 1'b1, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, "R7");
    run(2'd2, 1'b1, 32'h8000_0000, 32'h0, 32'h8000_0000, "R7");
    run(2'd2, 1'b1, 32'hC000_0000, 32'h0, 32'h8000_0000, "R7");
    run(2'd2, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");

    // R9: start while busy is ignored
    issue(2'd1, 1'b0, 32'h0, 32'h0000_0064, 32'h7, "R9");
    @(negedge clk);
    size = 2'd0; sgn = 1'b1; hi_in = 32'hFFFF_FFFF; lo_in = 32'h1; divisor = 32'h0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    for (int i = 0; i < 300; i++) begin
      logic [1:0]  s;
      logic        g;
      logic [63:0] dd;
      logic [31:0] h, l, d;
      int n;
      s = 2'($urandom % 4);
      g = 1'($urandom);
      n = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      dd = {$urandom, $urandom};
      if (i % 2 == 0) begin
        dd = dd & ((64'd1 << n) - 64'd1);
        if (g && dd[n-1]) dd = dd | ~((64'd1 << n) - 64'd1);
      end
      if (i % 25 == 0 && g) dd = (n == 32) ? 64'h8000_0000_0000_0000 : (64'd1 << (2*n-1));
      pack(s, dd, h, l);
      d = $urandom;
      if (i % 3 == 0) d = {d[31:8], 8'd0} | 32'($urandom % 9);
      run(s, g, h, l, d, g ? "R5" : "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule